// File: doc/BRIEF.md
# SCSI Controller Register Front-End

This block is the byte-wide register window of a legacy SCSI protocol controller. A host bus reaches sixteen byte registers through a 6-bit address window. Some addresses show a different register depending on the direction: a write lands in a configuration or hidden image, and a read returns live status. The block keeps the 16-bit transfer counter, decodes command bytes and updates the status, interrupt and sequence-step registers. It also drives a level interrupt to the host and holds a small byte FIFO for command and response bytes moved by programmed I/O.

The bus phase engine, the DMA engine and the attached target are outside the block. Three inputs report on them: a target-present level, the phase reported by that target, and a one-cycle strobe at the end of a DMA transfer. A separate input supplies the response byte that a completion command places in the FIFO. Read data is registered: `bus_rdata` holds the value selected by a read one clock after `bus_rd` is sampled. Reads and writes are assumed not to occur in the same cycle.

Top module: `scsi_regfront`

## Requirements
- R1: The register index is `bus_addr[5:2]`, and address bits 7:6 and 1:0 are ignored. A read returns in `bus_rdata` one clock later. Read map by index: 0 count low, 1 count mid, 2 FIFO byte, 3 last command byte, 4 status, 5 interrupt, 6 sequence step, 7 FIFO flags, 8 config 1, 11 config 2, 12 to 15 extension bytes. Indices 9 and 10 read 0.
- R2: Writes to indices 4, 5, 6, 7, 9 and 10 leave every read image unchanged. Index 11 keeps only `wdata & 0x15`. Indices 8 and 12 to 15 keep the whole byte.
- R3: Writes to index 0 or 1 go to hidden count bytes and clear status bit 0x10. The readable count copies the hidden bytes only when a command byte with bit 7 set is written. `xfer_len` is the readable count, or 65536 when that count is 0.
- R4: Reading index 5 returns the interrupt register. It clears status bits 0x80, 0x40 and 0x20 and drops `irq`.
- R5: Command code 0x03 (bus reset) sets the interrupt register to 0x80. It raises `irq` only if bit 6 of config 1 is 0.
- R6: Command code 0x01 (flush) sets the interrupt register to 0x08, clears the sequence step and empties the FIFO.
- R7: Command code 0x02 and the `rst` input clear every register, the hidden count bytes, the DMA mode, the FIFO and `irq`, and set index 14 to 0x04.
- R8: FIFO writes at index 2 append a byte while fewer than 32 are held, and further bytes are dropped. A read at index 2 with bytes held returns the oldest byte and raises `irq`. A read with the FIFO empty returns the last byte read and leaves `irq` unchanged.
- R9: Command code 0x11 (completion) with bit 7 clear loads the FIFO with `resp_byte` then 0x00, sets flags to 2 and raises `irq`. With bit 7 set it instead writes status 0x93, interrupt 0x18 and sequence 4, and raises `irq`. Code 0x12 (message accepted) does the same, then overrides interrupt to 0x20 and sequence to 0.
- R10: Codes 0x42 and 0x43 (select) always raise `irq`. With no target present they set status 0x80, interrupt 0x20 and sequence 0. With a target present, interrupt becomes 0x18 and sequence 4. Status becomes `0x90 | tgt_phase` for 0x42, and 0x92 for 0x43. In DMA mode, code 0x10 clears status bit 0x10.
- R11: A `xfer_done` pulse ORs 0x90 into status and sets interrupt to 0x10. It clears the sequence step, the flags and the readable count, and raises `irq`.
- R12: `irq` is a registered level. When a raising event and an interrupt-register read occur in the same cycle, `irq` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Host byte address; bits 5:2 select the register |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tgt_present | input | 1 | A target answers selection |
| tgt_phase | input | 3 | Bus phase reported by the selected target |
| resp_byte | input | 8 | Status byte placed in the FIFO by completion commands |
| xfer_done | input | 1 | One-cycle end-of-DMA-transfer pulse |
| irq | output | 1 | Level interrupt to the host |
| xfer_len | output | 17 | Effective transfer length in bytes |

## Verification
The bench targets the split between hidden and readable count bytes. A design that copied written count bytes straight into the readable count would show the new value before any DMA command is written. It also reads the status register after an interrupt read. A block that cleared the whole status register, or left bit 0x80 set, would fail there. The FIFO is driven past 32 bytes and read past empty, where a wrapping pointer would return overwritten or stale data. Further targets are the config-1 gate on the bus-reset interrupt and the cycle in which `xfer_done` and an interrupt read coincide, where a clear-wins design would drop `irq`.

// File: rtl/scsi_rf_pkg.sv
package scsi_rf_pkg;

    localparam int DW = 8;

    localparam logic [3:0] IX_CNT_LO = 4'd0;
    localparam logic [3:0] IX_CNT_MID = 4'd1;
    localparam logic [3:0] IX_FIFO = 4'd2;
    localparam logic [3:0] IX_CMD = 4'd3;
    localparam logic [3:0] IX_STAT = 4'd4;
    localparam logic [3:0] IX_INTR = 4'd5;
    localparam logic [3:0] IX_SEQ = 4'd6;
    localparam logic [3:0] IX_FLAGS = 4'd7;
    localparam logic [3:0] IX_CFG1 = 4'd8;
    localparam logic [3:0] IX_CFG2 = 4'd11;

    // status bits
    localparam logic [7:0] ST_INT = 8'h80;
    localparam logic [7:0] ST_ERR_MASK = 8'hE0;
    localparam logic [7:0] ST_TCNT = 8'h10;
    localparam logic [7:0] ST_DONE_SET = 8'h90;
    localparam logic [7:0] ST_RESP_DMA = 8'h93;
    localparam logic [7:0] ST_SEL_STOP = 8'h92;
    // interrupt codes
    localparam logic [7:0] IN_BUSRST = 8'h80;
    localparam logic [7:0] IN_DISC = 8'h20;
    localparam logic [7:0] IN_SVC = 8'h10;
    localparam logic [7:0] IN_FDONE = 8'h08;
    localparam logic [7:0] IN_SVC_FDONE = 8'h18;

    localparam logic [7:0] SEQ_CMD_DONE = 8'h04;
    localparam logic [7:0] CFG2_KEEP = 8'h15;
    localparam logic [7:0] REV_ID = 8'h04;
    localparam int CFG1_QUIET_BIT = 6;

    typedef enum logic [3:0] {
        OP_NOP, OP_FLUSH, OP_CHIPRST, OP_BUSRST, OP_XFER, OP_CMPL,
        OP_MSGOK, OP_ATN, OP_SELATN, OP_SELSTOP, OP_ENSEL, OP_OTHER
    } op_e;

    typedef struct packed {
        logic dma;
        op_e  op;
    } cmd_t;

    typedef struct packed {
        logic [7:0]      cnt_lo;
        logic [7:0]      cnt_mid;
        logic [7:0]      fifo;
        logic [7:0]      cmd;
        logic [7:0]      stat;
        logic [7:0]      intr;
        logic [7:0]      seq;
        logic [7:0]      flags;
        logic [7:0]      cfg1;
        logic [7:0]      cfg2;
        logic [3:0][7:0] ext;
    } rimg_t;

    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t c;
        c.dma = b[7];
        case (b[6:0])
            7'h00:   c.op = OP_NOP;
            7'h01:   c.op = OP_FLUSH;
            7'h02:   c.op = OP_CHIPRST;
            7'h03:   c.op = OP_BUSRST;
            7'h10:   c.op = OP_XFER;
            7'h11:   c.op = OP_CMPL;
            7'h12:   c.op = OP_MSGOK;
            7'h1A:   c.op = OP_ATN;
            7'h42:   c.op = OP_SELATN;
            7'h43:   c.op = OP_SELSTOP;
            7'h44:   c.op = OP_ENSEL;
            default: c.op = OP_OTHER;
        endcase
        return c;
    endfunction

    function automatic rimg_t reset_image();
        rimg_t r;
        r = '0;
        r.ext[2] = REV_ID;
        return r;
    endfunction

    function automatic logic [7:0] read_mux(input rimg_t r, input logic [3:0] i);
        case (i)
            4'd0:    return r.cnt_lo;
            4'd1:    return r.cnt_mid;
            4'd2:    return r.fifo;
            4'd3:    return r.cmd;
            4'd4:    return r.stat;
            4'd5:    return r.intr;
            4'd6:    return r.seq;
            4'd7:    return r.flags;
            4'd8:    return r.cfg1;
            4'd11:   return r.cfg2;
            4'd12, 4'd13, 4'd14, 4'd15: return r.ext[i[1:0]];
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/scsi_rf_cmd_dec.sv
module scsi_rf_cmd_dec
    import scsi_rf_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output cmd_t       dec
);
    always_comb dec = decode_cmd(cmd_byte);
endmodule

// File: rtl/scsi_rf_fifo.sv
module scsi_rf_fifo #(
    parameter int DEPTH = 32,
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         load2,
    input  logic [W-1:0] b0,
    input  logic [W-1:0] b1,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_p, wr_p;
    logic [CW-1:0] cnt;
    logic          full;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign dout  = mem[rd_p];

    always_ff @(posedge clk) begin
        if (load2) begin
            mem[0] <= b0;
            mem[1] <= b1;
        end else if (push && !full) begin
            mem[wr_p] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_p <= '0;
            wr_p <= '0;
            cnt  <= '0;
        end else if (load2) begin
            rd_p <= '0;
            wr_p <= AW'(2);
            cnt  <= CW'(2);
        end else if (push && !full) begin
            wr_p <= wr_p + 1'b1;
            cnt  <= cnt + 1'b1;
        end else if (pop && !empty) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
                rd_p <= '0;
                wr_p <= '0;
            end else begin
                rd_p <= rd_p + 1'b1;
            end
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(DEPTH)); // R8
    AST_FIFO_EMPTY_HOME: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) |-> (rd_p == '0 && wr_p == '0)); // R8
endmodule

// File: rtl/scsi_regfront.sv
module scsi_regfront
    import scsi_rf_pkg::*;
#(
    parameter int FIFO_DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        tgt_present,
    input  logic [2:0]  tgt_phase,
    input  logic [7:0]  resp_byte,
    input  logic        xfer_done,
    output logic        irq,
    output logic [16:0] xfer_len
);
    rimg_t      cur, nxt;
    logic [7:0] hid_lo, hid_mid, nxt_hid_lo, nxt_hid_mid;
    logic       dma_on, nxt_dma;
    logic       raise, lower;
    logic [3:0] idx;
    cmd_t       dec;
    logic       wr_cmd, chip_rst;
    logic       f_push, f_pop, f_clr, f_load, f_empty;
    logic [7:0] f_dout;
    logic       unused_addr_bits;

    assign idx = bus_addr[5:2];
    assign unused_addr_bits = ^{bus_addr[7:6], bus_addr[1:0]};

    scsi_rf_cmd_dec u_dec (.cmd_byte(bus_wdata), .dec(dec));

    assign wr_cmd   = bus_wr && (idx == IX_CMD);
    assign chip_rst = wr_cmd && (dec.op == OP_CHIPRST);
    assign f_push   = bus_wr && (idx == IX_FIFO);
    assign f_pop    = bus_rd && (idx == IX_FIFO) && !f_empty;
    assign f_clr    = wr_cmd && (dec.op == OP_FLUSH || dec.op == OP_CHIPRST);
    assign f_load   = wr_cmd && !dec.dma && (dec.op == OP_CMPL || dec.op == OP_MSGOK);

    scsi_rf_fifo #(.DEPTH(FIFO_DEPTH), .W(DW)) u_fifo (
        .clk(clk), .rst(rst), .clr(f_clr), .push(f_push), .din(bus_wdata),
        .pop(f_pop), .load2(f_load), .b0(resp_byte), .b1(8'h00),
        .dout(f_dout), .empty(f_empty)
    );

    always_comb begin
        nxt         = cur;
        nxt_hid_lo  = hid_lo;
        nxt_hid_mid = hid_mid;
        nxt_dma     = dma_on;
        raise       = 1'b0;
        lower       = 1'b0;
        if (bus_rd && idx == IX_INTR) begin
            nxt.stat = cur.stat & ~ST_ERR_MASK;
            lower    = 1'b1;
        end
        if (f_pop) begin
            nxt.fifo = f_dout;
            raise    = 1'b1;
        end
        if (xfer_done) begin
            nxt.stat    = nxt.stat | ST_DONE_SET;
            nxt.intr    = IN_SVC;
            nxt.seq     = '0;
            nxt.flags   = '0;
            nxt.cnt_lo  = '0;
            nxt.cnt_mid = '0;
            raise       = 1'b1;
        end
        if (bus_wr) begin
            case (idx)
                IX_CNT_LO: begin
                    nxt_hid_lo = bus_wdata;
                    nxt.stat   = nxt.stat & ~ST_TCNT;
                end
                IX_CNT_MID: begin
                    nxt_hid_mid = bus_wdata;
                    nxt.stat    = nxt.stat & ~ST_TCNT;
                end
                IX_CMD: begin
                    nxt.cmd = bus_wdata;
                    nxt_dma = dec.dma;
                    if (dec.dma) begin
                        nxt.cnt_lo  = hid_lo;
                        nxt.cnt_mid = hid_mid;
                    end
                    case (dec.op)
                        OP_FLUSH: begin
                            nxt.intr = IN_FDONE;
                            nxt.seq  = '0;
                        end
                        OP_BUSRST: begin
                            nxt.intr = IN_BUSRST;
                            raise    = raise | !cur.cfg1[CFG1_QUIET_BIT];
                        end
                        OP_XFER: if (dec.dma) nxt.stat = nxt.stat & ~ST_TCNT;
                        OP_CMPL, OP_MSGOK: begin
                            if (dec.dma) begin
                                nxt.stat = ST_RESP_DMA;
                                nxt.intr = IN_SVC_FDONE;
                                nxt.seq  = SEQ_CMD_DONE;
                            end else begin
                                nxt.flags = 8'h02;
                            end
                            if (dec.op == OP_MSGOK) begin
                                nxt.intr = IN_DISC;
                                nxt.seq  = '0;
                            end
                            raise = 1'b1;
                        end
                        OP_SELATN, OP_SELSTOP: begin
                            if (!tgt_present) begin
                                nxt.stat = ST_INT;
                                nxt.intr = IN_DISC;
                                nxt.seq  = '0;
                            end else begin
                                nxt.stat = (dec.op == OP_SELSTOP) ? ST_SEL_STOP
                                                                  : (ST_DONE_SET | {5'b0, tgt_phase});
                                nxt.intr = IN_SVC_FDONE;
                                nxt.seq  = SEQ_CMD_DONE;
                            end
                            raise = 1'b1;
                        end
                        default: ;
                    endcase
                end
                IX_CFG1: nxt.cfg1 = bus_wdata;
                IX_CFG2: nxt.cfg2 = bus_wdata & CFG2_KEEP;
                4'd12, 4'd13, 4'd14, 4'd15: nxt.ext[idx[1:0]] = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || chip_rst) begin
            cur     <= reset_image();
            hid_lo  <= '0;
            hid_mid <= '0;
            dma_on  <= 1'b0;
            irq     <= 1'b0;
        end else begin
            cur     <= nxt;
            hid_lo  <= nxt_hid_lo;
            hid_mid <= nxt_hid_mid;
            dma_on  <= nxt_dma;
            irq     <= raise ? 1'b1 : (lower ? 1'b0 : irq);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= f_pop ? f_dout : read_mux(cur, idx);
    end

    assign xfer_len = ({cur.cnt_mid, cur.cnt_lo} == 16'h0) ? 17'h10000
                                                          : {1'b0, cur.cnt_mid, cur.cnt_lo};

    AST_TC_WR_CLR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (idx == IX_CNT_LO || idx == IX_CNT_MID) && !xfer_done) |=> !cur.stat[4]); // R3
    AST_INTR_RD_CLR: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && idx == IX_INTR && !bus_wr && !xfer_done) |=> (!irq && cur.stat[7:5] == 3'b000)); // R4
    AST_CFG2_KEEP: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && idx == IX_CFG2) |=> (cur.cfg2 == ($past(bus_wdata) & CFG2_KEEP))); // R2
    AST_CHIP_RST: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && idx == IX_CMD && bus_wdata[6:0] == 7'h02) |=> (!irq && cur.ext[2] == REV_ID && cur.stat == 8'h00)); // R7
    AST_BUSRST_QUIET: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && idx == IX_CMD && bus_wdata[6:0] == 7'h03 && cur.cfg1[6] && !irq && !xfer_done) |=> !irq); // R5
    AST_DONE_IRQ: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !(bus_wr && idx == IX_CMD && bus_wdata[6:0] == 7'h02)) |=> irq); // R12
endmodule

// File: tb/sim_scsi_regfront.sv
module sim_scsi_regfront;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        tgt_present = 1'b0;
    logic [2:0]  tgt_phase = '0;
    logic [7:0]  resp_byte = '0;
    logic        xfer_done = 1'b0;
    logic        irq;
    logic [16:0] xfer_len;

    int checks = 0;
    int fails = 0;

    logic [7:0] img [16];
    logic [7:0] hlo, hmid;
    logic       mirq;
    logic [7:0] q [$];

    always #10 clk = ~clk;

    scsi_regfront u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tgt_present(tgt_present),
        .tgt_phase(tgt_phase), .resp_byte(resp_byte), .xfer_done(xfer_done),
        .irq(irq), .xfer_len(xfer_len)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        foreach (img[i]) img[i] = 8'h00;
        img[14] = 8'h04;
        hlo = 0; hmid = 0; mirq = 0;
        q.delete();
    endtask

    task automatic check_outs(input string tag);
        int n;
        n = {img[1], img[0]};
        cmp({tag, " irq"}, int'(irq), int'(mirq));
        cmp("R3 xfer_len", int'(xfer_len), (n == 0) ? 65536 : n);
    endtask

    task automatic m_write(input int idx, input logic [7:0] v);
        logic [6:0] c;
        c = v[6:0];
        case (idx)
            0: begin hlo = v; img[4] &= 8'hEF; end
            1: begin hmid = v; img[4] &= 8'hEF; end
            2: if (q.size() < 32) q.push_back(v);
            3: begin
                if (c == 7'h02) begin m_reset(); return; end
                img[3] = v;
                if (v[7]) begin img[0] = hlo; img[1] = hmid; end
                case (c)
                    7'h01: begin img[5] = 8'h08; img[6] = 0; q.delete(); end
                    7'h03: begin img[5] = 8'h80; if (!img[8][6]) mirq = 1; end
                    7'h10: if (v[7]) img[4] &= 8'hEF;
                    7'h11, 7'h12: begin
                        if (v[7]) begin img[4] = 8'h93; img[5] = 8'h18; img[6] = 4; end
                        else begin q.delete(); q.push_back(resp_byte); q.push_back(8'h00); img[7] = 2; end
                        if (c == 7'h12) begin img[5] = 8'h20; img[6] = 0; end
                        mirq = 1;
                    end
                    7'h42, 7'h43: begin
                        if (!tgt_present) begin img[4] = 8'h80; img[5] = 8'h20; img[6] = 0; end
                        else begin
                            img[4] = (c == 7'h43) ? 8'h92 : (8'h90 | {5'b0, tgt_phase});
                            img[5] = 8'h18; img[6] = 4;
                        end
                        mirq = 1;
                    end
                    default: ;
                endcase
            end
            8: img[8] = v;
            11: img[11] = v & 8'h15;
            12, 13, 14, 15: img[idx] = v;
            default: ;
        endcase
    endtask

    task automatic m_read(input int idx, output logic [7:0] exp);
        if (idx == 2 && q.size() > 0) begin
            img[2] = q.pop_front();
            mirq = 1;
        end
        exp = img[idx];
        if (idx == 5) begin img[4] &= 8'h1F; mirq = 0; end
    endtask

    task automatic m_done();
        img[4] |= 8'h90; img[5] = 8'h10;
        img[6] = 0; img[7] = 0; img[0] = 0; img[1] = 0;
        mirq = 1;
    endtask

    function automatic logic [7:0] mk_addr(input int idx, input bit alias_bits);
        return {alias_bits ? 2'b10 : 2'b00, 4'(idx), alias_bits ? 2'b11 : 2'b00};
    endfunction

    task automatic bwr(input int idx, input logic [7:0] v, input string tag, input bit al = 0);
        @(negedge clk);
        bus_addr = mk_addr(idx, al); bus_wdata = v; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
        m_write(idx, v);
        check_outs(tag);
    endtask

    task automatic brd(input int idx, input string tag, input bit al = 0, input bit with_done = 0);
        logic [7:0] e;
        @(negedge clk);
        bus_addr = mk_addr(idx, al); bus_rd = 1; xfer_done = with_done;
        @(negedge clk);
        bus_rd = 0; xfer_done = 0;
        m_read(idx, e);
        if (with_done) m_done();
        cmp(tag, int'(bus_rdata), int'(e));
        check_outs(tag);
    endtask

    task automatic pulse_done();
        @(negedge clk);
        xfer_done = 1;
        @(negedge clk);
        xfer_done = 0;
        m_done();
        check_outs("R11");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        check_outs("R7 reset");
        for (int i = 0; i < 16; i++) brd(i, "R7 reset image R1");

        // R2 / R1 aliasing
        bwr(8, 8'hC5, "R2", 1);
        bwr(11, 8'hFF, "R2");
        bwr(12, 8'hA1, "R2"); bwr(13, 8'hB2, "R2"); bwr(15, 8'hD4, "R2");
        bwr(4, 8'h07, "R2"); bwr(5, 8'hFF, "R2"); bwr(6, 8'h55, "R2");
        bwr(7, 8'h33, "R2"); bwr(9, 8'h77, "R2"); bwr(10, 8'h99, "R2");
        for (int i = 4; i < 16; i++) brd(i, "R2 read image", 1);
        bwr(8, 8'h00, "R2");

        // R3 hidden count
        bwr(0, 8'h34, "R3"); bwr(1, 8'h12, "R3");
        brd(0, "R3 count before DMA cmd");
        bwr(3, 8'h80, "R3 DMA nop");
        brd(0, "R3 count lo"); brd(1, "R3 count mid");

        // R11 done, then TC clears
        pulse_done();
        brd(4, "R11 status"); brd(6, "R11 seq");
        brd(5, "R4 intr read"); brd(4, "R4 status after clear");
        bwr(0, 8'h01, "R3 TC clear");
        brd(4, "R3 status TC");
        pulse_done();
        brd(5, "R4");
        bwr(3, 8'h90, "R10 dma xfer");
        brd(4, "R10 dma xfer clears TC");

        // R8 FIFO
        bwr(2, 8'h11, "R8"); bwr(2, 8'h22, "R8"); bwr(2, 8'h33, "R8");
        brd(2, "R8 pop"); brd(2, "R8 pop"); brd(2, "R8 pop");
        brd(5, "R4");
        brd(2, "R8 empty read");
        for (int i = 0; i < 34; i++) bwr(2, 8'(i + 8'h40), "R8 fill");
        for (int i = 0; i < 33; i++) brd(2, "R8 drain");
        brd(5, "R4");

        // R6 flush
        bwr(2, 8'hAA, "R6"); bwr(2, 8'hBB, "R6");
        bwr(3, 8'h01, "R6 flush");
        brd(5, "R6 intr"); brd(6, "R6 seq"); brd(2, "R6 fifo empty");

        // R5 bus reset gate
        bwr(3, 8'h03, "R5 bus reset loud");
        brd(5, "R5 intr code");
        bwr(8, 8'h40, "R5");
        bwr(3, 8'h03, "R5 bus reset quiet");
        brd(5, "R5 intr quiet");
        bwr(8, 8'h00, "R5");

        // R9 completion
        resp_byte = 8'h02;
        bwr(3, 8'h11, "R9 pio cmpl");
        brd(7, "R9 flags"); brd(2, "R9 resp"); brd(2, "R9 msg"); brd(5, "R9 intr");
        bwr(3, 8'h91, "R9 dma cmpl");
        brd(4, "R9 dma status"); brd(5, "R9 dma intr"); brd(6, "R9 dma seq");
        resp_byte = 8'h08;
        bwr(3, 8'h12, "R9 msg ok");
        brd(5, "R9 msg ok intr"); brd(6, "R9 msg ok seq"); brd(2, "R9 msg ok fifo");
        bwr(3, 8'h92, "R9 dma msg ok");
        brd(4, "R9 dma msg status"); brd(5, "R9 dma msg intr");

        // R10 select
        tgt_present = 0;
        bwr(3, 8'h42, "R10 absent");
        brd(4, "R10 absent status"); brd(5, "R10 absent intr"); brd(6, "R10 absent seq");
        tgt_present = 1; tgt_phase = 3'd1;
        bwr(3, 8'hC2, "R10 present");
        brd(4, "R10 present status"); brd(5, "R10 intr"); brd(6, "R10 seq");
        bwr(3, 8'h43, "R10 stop");
        brd(4, "R10 stop status"); brd(5, "R10");
        bwr(3, 8'h1A, "R10 atn"); bwr(3, 8'h44, "R10 ensel"); bwr(3, 8'h00, "R10 nop");

        // R12 set wins
        brd(5, "R12 read with done", 0, 1);
        brd(4, "R12 status");
        brd(5, "R12 clear");

        // R7 chip reset
        bwr(12, 8'h5A, "R7"); bwr(2, 8'h66, "R7"); pulse_done();
        bwr(3, 8'h02, "R7 chip reset");
        for (int i = 0; i < 16; i++) brd(i, "R7 after chip reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule